// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block makes the system reset for a processor supervisor. An external comparator supplies a flag that says the supply is below its threshold. An operator or a board-level button supplies an active-low manual reset request. The block turns these two inputs into a single reset interval and drives it out in three forms:

- an active-low push-pull level;
- its active-high complement;
- a pull-down enable for an open-drain pad.

While the supply flag is set, reset is held. Once the flag clears, reset is stretched for a fixed number of clock ticks (200 ms at the default 1 MHz tick rate) so that the rails can settle before the processor runs.

A supply dip that arrives while a reset interval is already running does not cut that interval short. The running interval keeps counting through the dip. After recovery, release happens at whichever comes later: the original end, or a guaranteed minimum interval (140 ms by default) measured from recovery.

The manual request is filtered so that short glitches are ignored. A request that stays stable for long enough starts a fresh, full-length interval. Both raw inputs are resynchronised to the block clock before use.

Top module: `sup_reset_gen`

## Requirements
- R1: While the synchronised supply-low flag is 1, reset is asserted (`rstOutN` = 0); when the raw flag rises from an idle state, `rstOutN` goes low on the third rising clock edge after the change.
- R2: After the supply-low flag clears from a fresh hold, reset stays asserted for `PULSE_TICKS` clock cycles, counted from the first cycle in which the synchronised flag reads 0, and is then released (`rstOutN` = 1).
- R3: If the supply-low flag rises while an interval is running, reset stays asserted through the dip. After recovery it is released at the later of two points: the original end of the interval, or `MIN_TICKS` cycles after the synchronised flag returns to 0.
- R4: A low level on `manRstInN` is accepted only after the synchronised input has differed from the filtered level for `DEB_TICKS` consecutive cycles; a shorter low glitch leaves `rstOutN` at 1.
- R5: An accepted manual request (filtered level falling from 1 to 0) starts a full `PULSE_TICKS` interval; if an interval is already running, it restarts from full length.
- R6: `rstOutHi` equals the inverse of `rstOutN` in every cycle.
- R7: `rstOdPullEn` is 1 exactly in the cycles where `rstOutN` is 0.
- R8: While `porClr` is 1 at a rising edge, reset is asserted on the next cycle and the interval counter is loaded with `PULSE_TICKS`; reset releases `PULSE_TICKS` cycles after the last edge with `porClr` = 1.
- R9: Both `supplyLowIn` and `manRstInN` pass through a two-flop synchroniser; a change on `supplyLowIn` has no effect on the outputs before the third rising edge after it.
- R10: If an accepted manual request and a rising supply-low flag reach the controller in the same cycle while reset is released, the supply flag wins. Reset is held, and the full interval is counted from supply recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; its rate sets the meaning of the tick parameters |
| porClr | input | 1 | Synchronous power-up clear, active high |
| supplyLowIn | input | 1 | Supply-below-threshold flag from the external comparator, asynchronous |
| manRstInN | input | 1 | Manual reset request, active low, asynchronous and bouncy |
| rstOutN | output | 1 | Reset, active low, push-pull level |
| rstOutHi | output | 1 | Reset, active high, complement of `rstOutN` |
| rstOdPullEn | output | 1 | Pull-down enable for an open-drain reset pad, 1 while reset is asserted |

## Verification
Two events can reach the controller in the same cycle: an accepted manual request and a rising supply-low flag. The bench provokes this by lowering `manRstInN` and then raising `supplyLowIn` exactly `DEB_TICKS - 1` cycles later, so that the filter output and the second synchroniser stage change on the same edge. The outcome is judged by the release time. Reset must be released `PULSE_TICKS` cycles after supply recovery, not at a time counted from the manual request. The same coincidence is also applied during a running interval, where both strobes must agree with the extend-after-brownout rule.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_BROWN = 2'd3
  } rstState_e;

  typedef struct packed {
    logic loadFull;
    logic floorMin;
    logic decr;
    logic assertRst;
  } rstStrobe_t;

endpackage

// File: rtl/sup_reset_sync.sv
module sup_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shiftQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) shiftQ <= din;
    end else begin : g_chain
      always_ff @(posedge clk) shiftQ <= {shiftQ[STAGES-2:0], din};
    end
  endgenerate

  assign dout = shiftQ[STAGES-1];

endmodule

// File: rtl/sup_reset_debounce.sv
module sup_reset_debounce #(
  parameter int STABLE_TICKS = 1000
) (
  input  logic clk,
  input  logic porClr,
  input  logic syncIn,
  output logic mrAssert
);

  localparam int CW = (STABLE_TICKS < 2) ? 1 : $clog2(STABLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic          debLevel;
  logic [CW-1:0] stableCnt;
  logic          differs;
  logic          accept;

  assign differs  = (syncIn != debLevel);
  assign accept   = differs && (stableCnt == LAST);
  assign mrAssert = accept && !syncIn;

  always_ff @(posedge clk) begin
    if (porClr) begin
      debLevel  <= 1'b1;
      stableCnt <= '0;
    end else if (!differs) begin
      stableCnt <= '0;
    end else if (accept) begin
      debLevel  <= syncIn;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // R4: the filtered level only ever moves to the value the synchroniser held
  a_r4_level_follows_input: assert property (@(posedge clk) disable iff (porClr)
    !$stable(debLevel) |-> (debLevel == $past(syncIn)));

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_reset_pkg::*;
(
  input  logic       clk,
  input  logic       porClr,
  input  logic       supLow,
  input  logic       mrAssert,
  input  logic       lastTick,
  output rstStrobe_t strobe
);

  rstState_e state;
  rstState_e stateNxt;
  logic      rstOn;

  assign rstOn = (state != ST_IDLE);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (porClr) begin
      stateNxt        = ST_RUN;
      strobe.loadFull = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (supLow) begin
            stateNxt        = ST_HOLD;
            strobe.loadFull = 1'b1;
          end else if (mrAssert) begin
            stateNxt        = ST_RUN;
            strobe.loadFull = 1'b1;
          end
        end
        ST_HOLD: begin
          strobe.loadFull = 1'b1;
          if (!supLow) stateNxt = ST_RUN;
        end
        ST_RUN: begin
          if (supLow) begin
            stateNxt = ST_BROWN;
            if (mrAssert) strobe.loadFull = 1'b1;
            else          strobe.decr     = 1'b1;
          end else if (mrAssert) begin
            strobe.loadFull = 1'b1;
          end else if (lastTick) begin
            stateNxt = ST_IDLE;
          end else begin
            strobe.decr = 1'b1;
          end
        end
        ST_BROWN: begin
          if (mrAssert)    strobe.loadFull = 1'b1;
          else if (supLow) strobe.decr     = 1'b1;
          else             strobe.floorMin = 1'b1;
          if (!supLow) stateNxt = ST_RUN;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
    strobe.assertRst = rstOn;
  end

  always_ff @(posedge clk) begin
    state <= stateNxt;
  end

  // R1: a synchronised supply-low flag always leaves reset asserted next cycle
  a_r1_low_forces_reset: assert property (@(posedge clk) disable iff (porClr)
    supLow |=> rstOn);

  // R2: reset only drops after the datapath reported the final tick
  a_r2_release_after_count: assert property (@(posedge clk) disable iff (porClr)
    $fell(rstOn) |-> $past(lastTick));

  // R5: an accepted manual request with the supply good asserts reset
  a_r5_manual_starts_pulse: assert property (@(posedge clk) disable iff (porClr)
    (mrAssert && !supLow) |=> rstOn);

  // R1: no release while the supply flag is still set
  a_r1_no_release_when_low: assert property (@(posedge clk) disable iff (porClr)
    (rstOn && supLow) |=> rstOn);

endmodule

// File: rtl/sup_reset_dpath.sv
module sup_reset_dpath
  import sup_reset_pkg::*;
#(
  parameter int PULSE_TICKS = 200000,
  parameter int MIN_TICKS   = 140000
) (
  input  logic       clk,
  input  logic       porClr,
  input  rstStrobe_t strobe,
  output logic       lastTick,
  output logic       rstOutN,
  output logic       rstOutHi,
  output logic       rstOdPullEn
);

  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] PULSE_C = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] MIN_C   = CW'(MIN_TICKS);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [CW-1:0] remainCnt;

  always_ff @(posedge clk) begin
    if (strobe.loadFull) begin
      remainCnt <= PULSE_C;
    end else if (strobe.floorMin) begin
      remainCnt <= (remainCnt < MIN_C) ? MIN_C : remainCnt;
    end else if (strobe.decr && (remainCnt != '0)) begin
      remainCnt <= remainCnt - 1'b1;
    end
  end

  assign lastTick    = (remainCnt == ONE_C);
  assign rstOutN     = ~strobe.assertRst;
  assign rstOutHi    = strobe.assertRst;
  assign rstOdPullEn = strobe.assertRst;

  // R3: recovery after a brownout always leaves at least the minimum interval
  a_r3_floor_after_brownout: assert property (@(posedge clk) disable iff (porClr)
    strobe.floorMin |=> (remainCnt >= MIN_C));

  // R2: the counter never underflows while reset is being timed
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (porClr)
    (strobe.decr && !strobe.loadFull && !strobe.floorMin && remainCnt == '0) |=> (remainCnt == '0));

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_reset_pkg::*;
#(
  parameter int PULSE_TICKS = 200000,
  parameter int MIN_TICKS   = 140000,
  parameter int DEB_TICKS   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porClr,
  input  logic supplyLowIn,
  input  logic manRstInN,
  output logic rstOutN,
  output logic rstOutHi,
  output logic rstOdPullEn
);

  logic       supLow;
  logic       mrSync;
  logic       mrAssert;
  logic       lastTick;
  rstStrobe_t strobe;

  sup_reset_sync #(.STAGES(SYNC_STAGES)) uSyncSupply (
    .clk  (clk),
    .din  (supplyLowIn),
    .dout (supLow)
  );

  sup_reset_sync #(.STAGES(SYNC_STAGES)) uSyncManual (
    .clk  (clk),
    .din  (manRstInN),
    .dout (mrSync)
  );

  sup_reset_debounce #(.STABLE_TICKS(DEB_TICKS)) uDebounce (
    .clk      (clk),
    .porClr   (porClr),
    .syncIn   (mrSync),
    .mrAssert (mrAssert)
  );

  sup_reset_ctrl uCtrl (
    .clk      (clk),
    .porClr   (porClr),
    .supLow   (supLow),
    .mrAssert (mrAssert),
    .lastTick (lastTick),
    .strobe   (strobe)
  );

  sup_reset_dpath #(
    .PULSE_TICKS (PULSE_TICKS),
    .MIN_TICKS   (MIN_TICKS)
  ) uDpath (
    .clk         (clk),
    .porClr      (porClr),
    .strobe      (strobe),
    .lastTick    (lastTick),
    .rstOutN     (rstOutN),
    .rstOutHi    (rstOutHi),
    .rstOdPullEn (rstOdPullEn)
  );

endmodule

// File: tb/sup_reset_gen_test.sv
module sup_reset_gen_test;

  localparam int P = 200;
  localparam int M = 140;
  localparam int D = 10;

  logic clk = 1'b0;
  logic porClr = 1'b1;
  logic supplyLowIn = 1'b0;
  logic manRstInN = 1'b1;
  logic rstOutN, rstOutHi, rstOdPullEn;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;

  typedef struct {
    int    cyc;
    bit    expLow;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  sup_reset_gen #(
    .PULSE_TICKS (P),
    .MIN_TICKS   (M),
    .DEB_TICKS   (D),
    .SYNC_STAGES (2)
  ) uut (
    .clk         (clk),
    .porClr      (porClr),
    .supplyLowIn (supplyLowIn),
    .manRstInN   (manRstInN),
    .rstOutN     (rstOutN),
    .rstOutHi    (rstOutHi),
    .rstOdPullEn (rstOdPullEn)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when their cycle comes up
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (rstOutHi !== ~rstOutN) begin
        failures++;
        $display("FAIL R6 cyc=%0d rstOutHi=%b expected %b", cyc, rstOutHi, ~rstOutN);
      end
      checks++;
      if (rstOdPullEn !== ~rstOutN) begin
        failures++;
        $display("FAIL R7 cyc=%0d rstOdPullEn=%b expected %b", cyc, rstOdPullEn, ~rstOutN);
      end
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        cur = q.pop_front();
        checks++;
        if (rstOutN !== !cur.expLow) begin
          failures++;
          $display("FAIL %s cyc=%0d rstOutN=%b expected %b", cur.req, cyc, rstOutN, !cur.expLow);
        end
      end
    end
  end

  task automatic expectAt(int c, bit low, string req);
    exp_t e;
    e.cyc = c;
    e.expLow = low;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic at(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    summary();
    $finish;
  end

  initial begin
    int t;
    // R8: power-up clear
    repeat (3) @(negedge clk);
    porClr = 1'b0;
    t = cyc;
    armed = 1'b1;
    expectAt(t + 1, 1, "R8");
    expectAt(t + P - 4, 1, "R8");
    expectAt(t + P + 3, 0, "R8");
    drain();

    // R1, R9, R2: plain supply dip from idle
    t = cyc;
    supplyLowIn = 1'b1;
    expectAt(t + 2, 0, "R9");
    expectAt(t + 3, 1, "R1");
    expectAt(t + 49, 1, "R1");
    expectAt(t + 50 + P - 3, 1, "R2");
    expectAt(t + 50 + P + 3, 0, "R2");
    at(t + 50);
    supplyLowIn = 1'b0;
    drain();

    // R3: late brownout, minimum interval after recovery dominates
    t = cyc;
    supplyLowIn = 1'b1;
    expectAt(t + 212, 1, "R3");
    expectAt(t + 264, 1, "R3");
    expectAt(t + 272, 0, "R3");
    at(t + 5);   supplyLowIn = 1'b0;
    at(t + 105); supplyLowIn = 1'b1;
    at(t + 125); supplyLowIn = 1'b0;
    drain();

    // R3: early brownout, original end dominates
    t = cyc;
    supplyLowIn = 1'b1;
    expectAt(t + 204, 1, "R3");
    expectAt(t + 213, 0, "R3");
    at(t + 5);  supplyLowIn = 1'b0;
    at(t + 20); supplyLowIn = 1'b1;
    at(t + 25); supplyLowIn = 1'b0;
    drain();

    // R4: short manual glitch is ignored
    t = cyc;
    manRstInN = 1'b0;
    expectAt(t + 5, 0, "R4");
    expectAt(t + 12, 0, "R4");
    expectAt(t + 20, 0, "R4");
    expectAt(t + 40, 0, "R4");
    at(t + 4); manRstInN = 1'b1;
    drain();

    // R5, R4: valid manual request from idle
    t = cyc;
    manRstInN = 1'b0;
    expectAt(t + 10, 0, "R4");
    expectAt(t + 14, 1, "R5");
    expectAt(t + 208, 1, "R5");
    expectAt(t + 215, 0, "R5");
    at(t + 30); manRstInN = 1'b1;
    drain();

    // R5: manual request restarts a running interval
    t = cyc;
    supplyLowIn = 1'b1;
    expectAt(t + 250, 1, "R5");
    expectAt(t + 308, 1, "R5");
    expectAt(t + 316, 0, "R5");
    at(t + 5);   supplyLowIn = 1'b0;
    at(t + 100); manRstInN = 1'b0;
    at(t + 130); manRstInN = 1'b1;
    drain();

    // R10: manual acceptance and supply rise coincide while idle
    t = cyc;
    manRstInN = 1'b0;
    expectAt(t + 14, 1, "R10");
    expectAt(t + 228, 1, "R10");
    expectAt(t + 236, 0, "R10");
    at(t + D - 1); supplyLowIn = 1'b1;
    at(t + 29);    supplyLowIn = 1'b0;
    at(t + 40);    manRstInN = 1'b1;
    drain();

    // R8: clear applied mid-operation
    t = cyc;
    porClr = 1'b1;
    expectAt(t + 2, 1, "R8");
    expectAt(t + P - 2, 1, "R8");
    expectAt(t + P + 5, 0, "R8");
    at(t + 1); porClr = 1'b0;
    drain();

    summary();
    $finish;
  end

endmodule